// File: doc/BRIEF.md
# Superscalar Dispatch Stall Controller

This block sits between a queue of already-decoded instructions and the out-of-order schedulers. In every cycle it looks at the instructions at the head of the queue, strictly oldest first, and decides how many of them leave as one dispatch group. An instruction joins the group only while every budget it draws on still has room after the older members of the group have taken their share. The budgets are reorder buffer entries (one per micro-op), free physical registers for renaming its destinations, a slot in the scheduler it targets, and a load queue or store queue entry if it is a memory access. The first instruction that does not fit ends the group. No younger instruction may pass it.

The dispatch decision is combinational. The queue pops `disp_count` entries at the next edge. The resource owners subtract the reported `used_*` amounts. When a group stops short because a queued instruction was refused, the block names one cause. It keeps a wrapping counter per cause and a histogram of how many instructions left in each cycle, so that a performance engineer can see where dispatch bandwidth went.

Top module: `dispatch_stall_ctrl`

## Requirements
- R1: Dispatch takes a contiguous prefix of the queue head. Slot 0 is the oldest instruction. `disp_count` never exceeds `q_count`.
- R2: A group holds at most the effective width. That width is `cfg_width`, except that a value of 0 selects `DEF_W` (2 by default) and a value above `MAX_W` (4) is clamped to `MAX_W`.
- R3: The micro-op counts of the dispatched instructions, summed, never exceed `rob_free`.
- R4: The destination counts of the dispatched instructions, summed, never exceed `prf_free`. When `cfg_prf_limit` is 0 the register file is unbounded and this check never refuses an instruction.
- R5: Each instruction names its scheduler in `q_sched`, one bit per slot with the default of two schedulers. The number dispatched to scheduler s never exceeds `sched_free` for s.
- R6: An instruction flagged as a load needs one free load queue entry. An instruction flagged as a store needs one free store queue entry. The entries are counted cumulatively across the group.
- R7: An instruction flagged `q_alone` may dispatch only as the first member of a group. Younger instructions may still follow it.
- R8: `stall_reason` is nonzero only when an instruction inside the queue and inside the width is refused. It then holds the first failing check in this order: 1 reorder buffer, 2 registers, 3 scheduler, 4 load queue, 5 store queue, 6 group restriction. Otherwise it is 0.
- R9: At each clock edge out of reset, the stall counter for the current nonzero reason increments by one. Reason k is held at bits `(k-1)*CNT_W +: CNT_W` of `stall_cnt`.
- R10: At each clock edge out of reset, histogram bin N increments when N instructions were dispatched that cycle. Bin N is held at bits `N*CNT_W +: CNT_W` of `hist_cnt`.
- R11: Synchronous reset clears every stall counter and histogram bin.
- R12: `used_rob`, `used_prf`, `used_sched`, `used_lq` and `used_sq` report the totals consumed by the dispatched instructions. `used_prf` reports the destination total even when the register file is unbounded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | WSEL_W | Requested dispatch width; 0 selects the default |
| cfg_prf_limit | input | FREE_W | Physical register limit; 0 means unbounded |
| q_count | input | WSEL_W | Number of valid instructions at the queue head |
| q_uops | input | MAX_W*UOP_W | Micro-op count per slot |
| q_dsts | input | MAX_W*DST_W | Destination register count per slot |
| q_is_load | input | MAX_W | Load flag per slot |
| q_is_store | input | MAX_W | Store flag per slot |
| q_alone | input | MAX_W | Must-lead-group flag per slot |
| q_sched | input | MAX_W*SCH_W | Target scheduler per slot |
| rob_free | input | FREE_W | Free reorder buffer entries |
| prf_free | input | FREE_W | Free physical registers |
| sched_free | input | NSCHED*FREE_W | Free entries per scheduler |
| lq_free | input | FREE_W | Free load queue entries |
| sq_free | input | FREE_W | Free store queue entries |
| disp_count | output | WSEL_W | Instructions dispatched this cycle |
| stall_reason | output | 3 | Cause of a short group (0 = none) |
| used_rob | output | FREE_W | Reorder buffer entries consumed |
| used_prf | output | FREE_W | Physical registers consumed |
| used_sched | output | NSCHED*FREE_W | Entries consumed per scheduler |
| used_lq | output | FREE_W | Load queue entries consumed |
| used_sq | output | FREE_W | Store queue entries consumed |
| stall_cnt | output | 6*CNT_W | Per-cause stall cycle counters |
| hist_cnt | output | (MAX_W+1)*CNT_W | Dispatch-count histogram |

## Verification
The group decision, `stall_reason` and the `used_*` totals depend on the current inputs through logic only, with no register in the path. The bench therefore drives each vector just after a falling edge and samples these outputs one nanosecond later, in the same cycle. The stall counters and histogram bins go through one register stage. They move at the next rising edge, so the bench compares them against its own tallies at a later falling edge. It does this only after it has counted exactly the edges it applied. The reset and idle checks follow the same rule: reset is held across edges, and the bins are read one half-period after the last counted edge.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    localparam int UOP_W   = 3;
    localparam int DST_W   = 2;
    localparam int NUM_RSN = 6;

    typedef enum logic [2:0] {
        RSN_NONE  = 3'd0,
        RSN_ROB   = 3'd1,
        RSN_REG   = 3'd2,
        RSN_SCHED = 3'd3,
        RSN_LQ    = 3'd4,
        RSN_SQ    = 3'd5,
        RSN_GROUP = 3'd6
    } stall_rsn_e;

    typedef struct packed {
        logic [UOP_W-1:0] uops;
        logic [DST_W-1:0] dsts;
        logic             is_ld;
        logic             is_st;
        logic             alone;
    } dinst_t;

    // Effective group width: zero picks the default, oversize clamps.
    function automatic int unsigned pick_width(int unsigned cfg,
                                               int unsigned max_w,
                                               int unsigned def_w);
        if (cfg == 0)
            return def_w;
        if (cfg > max_w)
            return max_w;
        return cfg;
    endfunction

endpackage

// File: rtl/dsc_slot_check.sv
module dsc_slot_check
    import dsc_pkg::*;
#(
    parameter int NSCHED   = 2,
    parameter int FREE_W   = 8,
    parameter int SCH_W    = 1,
    parameter bit IS_FIRST = 1'b0
) (
    input  logic                           in_play,
    input  dinst_t                         inst,
    input  logic [SCH_W-1:0]               sch_sel,
    input  logic [FREE_W-1:0]              rob_free,
    input  logic [FREE_W-1:0]              prf_free,
    input  logic                           prf_bounded,
    input  logic [NSCHED-1:0][FREE_W-1:0]  sched_free,
    input  logic [FREE_W-1:0]              lq_free,
    input  logic [FREE_W-1:0]              sq_free,
    input  logic [FREE_W-1:0]              rob_in,
    input  logic [FREE_W-1:0]              prf_in,
    input  logic [NSCHED-1:0][FREE_W-1:0]  sched_in,
    input  logic [FREE_W-1:0]              lq_in,
    input  logic [FREE_W-1:0]              sq_in,
    output logic                           go,
    output logic                           stop,
    output stall_rsn_e                     why,
    output logic [FREE_W-1:0]              rob_out,
    output logic [FREE_W-1:0]              prf_out,
    output logic [NSCHED-1:0][FREE_W-1:0]  sched_out,
    output logic [FREE_W-1:0]              lq_out,
    output logic [FREE_W-1:0]              sq_out
);

    localparam int SUM_W = FREE_W + 1;

    logic [SUM_W-1:0]  rob_need, prf_need, sel_need, lq_need, sq_need;
    logic [FREE_W-1:0] sel_free, sel_used;
    logic              sel_hit;
    logic              rob_ok, prf_ok, sch_ok, lq_ok, sq_ok, grp_ok, fits;

    always_comb begin
        rob_need = SUM_W'(rob_in) + SUM_W'(inst.uops);
        prf_need = SUM_W'(prf_in) + SUM_W'(inst.dsts);
        lq_need  = SUM_W'(lq_in) + SUM_W'(inst.is_ld);
        sq_need  = SUM_W'(sq_in) + SUM_W'(inst.is_st);

        sel_free = '0;
        sel_used = '0;
        sel_hit  = 1'b0;
        for (int s = 0; s < NSCHED; s++) begin
            if (SCH_W'(s) == sch_sel) begin
                sel_free = sched_free[s];
                sel_used = sched_in[s];
                sel_hit  = 1'b1;
            end
        end
        sel_need = SUM_W'(sel_used) + SUM_W'(1);

        rob_ok = rob_need <= SUM_W'(rob_free);
        prf_ok = !prf_bounded || (prf_need <= SUM_W'(prf_free));
        sch_ok = sel_hit && (sel_need <= SUM_W'(sel_free));
        lq_ok  = lq_need <= SUM_W'(lq_free);
        sq_ok  = sq_need <= SUM_W'(sq_free);
        grp_ok = IS_FIRST || !inst.alone;
        fits   = rob_ok && prf_ok && sch_ok && lq_ok && sq_ok && grp_ok;

        go   = in_play && fits;
        stop = in_play && !fits;

        if (!stop)        why = RSN_NONE;
        else if (!rob_ok) why = RSN_ROB;
        else if (!prf_ok) why = RSN_REG;
        else if (!sch_ok) why = RSN_SCHED;
        else if (!lq_ok)  why = RSN_LQ;
        else if (!sq_ok)  why = RSN_SQ;
        else              why = RSN_GROUP;

        rob_out = go ? rob_need[FREE_W-1:0] : rob_in;
        prf_out = go ? prf_need[FREE_W-1:0] : prf_in;
        lq_out  = go ? lq_need[FREE_W-1:0]  : lq_in;
        sq_out  = go ? sq_need[FREE_W-1:0]  : sq_in;
        for (int s = 0; s < NSCHED; s++) begin
            sched_out[s] = (go && SCH_W'(s) == sch_sel) ? sel_need[FREE_W-1:0]
                                                         : sched_in[s];
        end
    end

endmodule

// File: rtl/dsc_stats.sv
module dsc_stats
    import dsc_pkg::*;
#(
    parameter int MAX_W  = 4,
    parameter int CNT_W  = 16,
    parameter int WSEL_W = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [WSEL_W-1:0]            disp_count,
    input  stall_rsn_e                   stall_reason,
    output logic [NUM_RSN*CNT_W-1:0]     stall_cnt,
    output logic [(MAX_W+1)*CNT_W-1:0]   hist_cnt
);

    for (genvar b = 0; b <= MAX_W; b++) begin : g_bin
        logic [CNT_W-1:0] bin_q;
        always_ff @(posedge clk) begin
            if (rst)
                bin_q <= '0;
            else if (disp_count == WSEL_W'(b))
                bin_q <= bin_q + CNT_W'(1);
        end
        assign hist_cnt[b*CNT_W +: CNT_W] = bin_q;
    end

    for (genvar r = 0; r < NUM_RSN; r++) begin : g_rsn
        logic [CNT_W-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (rst)
                cnt_q <= '0;
            else if (stall_reason == stall_rsn_e'(3'(r + 1)))
                cnt_q <= cnt_q + CNT_W'(1);
        end
        assign stall_cnt[r*CNT_W +: CNT_W] = cnt_q;
    end

endmodule

// File: rtl/dispatch_stall_ctrl.sv
module dispatch_stall_ctrl
    import dsc_pkg::*;
#(
    parameter int MAX_W  = 4,
    parameter int DEF_W  = 2,
    parameter int NSCHED = 2,
    parameter int FREE_W = 8,
    parameter int CNT_W  = 16,
    localparam int WSEL_W = $clog2(MAX_W + 1),
    localparam int SCH_W  = (NSCHED > 1) ? $clog2(NSCHED) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [WSEL_W-1:0]           cfg_width,
    input  logic [FREE_W-1:0]           cfg_prf_limit,
    input  logic [WSEL_W-1:0]           q_count,
    input  logic [MAX_W*UOP_W-1:0]      q_uops,
    input  logic [MAX_W*DST_W-1:0]      q_dsts,
    input  logic [MAX_W-1:0]            q_is_load,
    input  logic [MAX_W-1:0]            q_is_store,
    input  logic [MAX_W-1:0]            q_alone,
    input  logic [MAX_W*SCH_W-1:0]      q_sched,
    input  logic [FREE_W-1:0]           rob_free,
    input  logic [FREE_W-1:0]           prf_free,
    input  logic [NSCHED*FREE_W-1:0]    sched_free,
    input  logic [FREE_W-1:0]           lq_free,
    input  logic [FREE_W-1:0]           sq_free,
    output logic [WSEL_W-1:0]           disp_count,
    output logic [2:0]                  stall_reason,
    output logic [FREE_W-1:0]           used_rob,
    output logic [FREE_W-1:0]           used_prf,
    output logic [NSCHED*FREE_W-1:0]    used_sched,
    output logic [FREE_W-1:0]           used_lq,
    output logic [FREE_W-1:0]           used_sq,
    output logic [NUM_RSN*CNT_W-1:0]    stall_cnt,
    output logic [(MAX_W+1)*CNT_W-1:0]  hist_cnt
);

    dinst_t                        slot     [MAX_W];
    logic [SCH_W-1:0]              slot_sch [MAX_W];
    logic [NSCHED-1:0][FREE_W-1:0] sched_av;
    logic [MAX_W-1:0]              in_range;
    logic [MAX_W:0]                chain;
    logic [MAX_W-1:0]              go_v, stop_v;
    stall_rsn_e                    why_v    [MAX_W];
    stall_rsn_e                    rsn;
    logic                          prf_bounded;
    int unsigned                   eff_w;

    logic [FREE_W-1:0]             rob_u    [MAX_W+1];
    logic [FREE_W-1:0]             prf_u    [MAX_W+1];
    logic [FREE_W-1:0]             lq_u     [MAX_W+1];
    logic [FREE_W-1:0]             sq_u     [MAX_W+1];
    logic [NSCHED-1:0][FREE_W-1:0] sch_u    [MAX_W+1];

    // Unpack the queue-head fields and resolve the effective width.
    always_comb begin
        eff_w       = pick_width(int'(cfg_width), MAX_W, DEF_W);
        prf_bounded = (cfg_prf_limit != '0);
        for (int i = 0; i < MAX_W; i++) begin
            slot[i].uops  = q_uops[i*UOP_W +: UOP_W];
            slot[i].dsts  = q_dsts[i*DST_W +: DST_W];
            slot[i].is_ld = q_is_load[i];
            slot[i].is_st = q_is_store[i];
            slot[i].alone = q_alone[i];
            slot_sch[i]   = q_sched[i*SCH_W +: SCH_W];
            in_range[i]   = (i < int'(eff_w)) && (i < int'(q_count));
        end
        for (int s = 0; s < NSCHED; s++)
            sched_av[s] = sched_free[s*FREE_W +: FREE_W];
    end

    assign chain[0] = 1'b1;
    assign rob_u[0] = '0;
    assign prf_u[0] = '0;
    assign lq_u[0]  = '0;
    assign sq_u[0]  = '0;
    assign sch_u[0] = '0;

    for (genvar i = 0; i < MAX_W; i++) begin : g_slot
        dsc_slot_check #(
            .NSCHED   (NSCHED),
            .FREE_W   (FREE_W),
            .SCH_W    (SCH_W),
            .IS_FIRST (i == 0)
        ) check_i (
            .in_play     (chain[i] && in_range[i]),
            .inst        (slot[i]),
            .sch_sel     (slot_sch[i]),
            .rob_free    (rob_free),
            .prf_free    (prf_free),
            .prf_bounded (prf_bounded),
            .sched_free  (sched_av),
            .lq_free     (lq_free),
            .sq_free     (sq_free),
            .rob_in      (rob_u[i]),
            .prf_in      (prf_u[i]),
            .sched_in    (sch_u[i]),
            .lq_in       (lq_u[i]),
            .sq_in       (sq_u[i]),
            .go          (go_v[i]),
            .stop        (stop_v[i]),
            .why         (why_v[i]),
            .rob_out     (rob_u[i+1]),
            .prf_out     (prf_u[i+1]),
            .sched_out   (sch_u[i+1]),
            .lq_out      (lq_u[i+1]),
            .sq_out      (sq_u[i+1])
        );
        assign chain[i+1] = go_v[i];
    end

    // Group size and the single reported cause of a short group.
    always_comb begin
        disp_count = '0;
        rsn        = RSN_NONE;
        for (int i = 0; i < MAX_W; i++) begin
            if (go_v[i])
                disp_count = disp_count + WSEL_W'(1);
            if (stop_v[i])
                rsn = why_v[i];
        end
    end

    assign stall_reason = rsn;
    assign used_rob     = rob_u[MAX_W];
    assign used_prf     = prf_u[MAX_W];
    assign used_lq      = lq_u[MAX_W];
    assign used_sq      = sq_u[MAX_W];

    for (genvar s = 0; s < NSCHED; s++) begin : g_used
        assign used_sched[s*FREE_W +: FREE_W] = sch_u[MAX_W][s];
    end

    dsc_stats #(
        .MAX_W  (MAX_W),
        .CNT_W  (CNT_W),
        .WSEL_W (WSEL_W)
    ) stats_i (
        .clk          (clk),
        .rst          (rst),
        .disp_count   (disp_count),
        .stall_reason (rsn),
        .stall_cnt    (stall_cnt),
        .hist_cnt     (hist_cnt)
    );

endmodule

// File: rtl/dispatch_stall_ctrl_chk.sv
module dispatch_stall_ctrl_chk
    import dsc_pkg::*;
#(
    parameter int MAX_W  = 4,
    parameter int DEF_W  = 2,
    parameter int NSCHED = 2,
    parameter int FREE_W = 8,
    parameter int CNT_W  = 16,
    localparam int WSEL_W = $clog2(MAX_W + 1)
) (
    input logic                        clk,
    input logic                        rst,
    input logic [WSEL_W-1:0]           cfg_width,
    input logic [FREE_W-1:0]           cfg_prf_limit,
    input logic [WSEL_W-1:0]           q_count,
    input logic [FREE_W-1:0]           rob_free,
    input logic [FREE_W-1:0]           prf_free,
    input logic [NSCHED*FREE_W-1:0]    sched_free,
    input logic [FREE_W-1:0]           lq_free,
    input logic [FREE_W-1:0]           sq_free,
    input logic [WSEL_W-1:0]           disp_count,
    input logic [2:0]                  stall_reason,
    input logic [FREE_W-1:0]           used_rob,
    input logic [FREE_W-1:0]           used_prf,
    input logic [NSCHED*FREE_W-1:0]    used_sched,
    input logic [FREE_W-1:0]           used_lq,
    input logic [FREE_W-1:0]           used_sq,
    input logic [NUM_RSN*CNT_W-1:0]    stall_cnt,
    input logic [(MAX_W+1)*CNT_W-1:0]  hist_cnt
);

    logic [CNT_W-1:0] hist_sum, stall_sum;
    int unsigned      eff_w;

    always_comb begin
        hist_sum  = '0;
        stall_sum = '0;
        for (int b = 0; b <= MAX_W; b++)
            hist_sum = hist_sum + hist_cnt[b*CNT_W +: CNT_W];
        for (int r = 0; r < NUM_RSN; r++)
            stall_sum = stall_sum + stall_cnt[r*CNT_W +: CNT_W];
        eff_w = pick_width(int'(cfg_width), MAX_W, DEF_W);
    end

    assert_in_queue_R1: assert property (@(posedge clk) disable iff (rst)
        disp_count <= q_count);

    assert_width_cap_R2: assert property (@(posedge clk) disable iff (rst)
        int'(disp_count) <= int'(eff_w));

    assert_rob_fit_R3: assert property (@(posedge clk) disable iff (rst)
        used_rob <= rob_free);

    assert_prf_fit_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_prf_limit != '0) |-> (used_prf <= prf_free));

    for (genvar s = 0; s < NSCHED; s++) begin : g_sch
        assert_sched_fit_R5: assert property (@(posedge clk) disable iff (rst)
            used_sched[s*FREE_W +: FREE_W] <= sched_free[s*FREE_W +: FREE_W]);
    end

    assert_lsq_fit_R6: assert property (@(posedge clk) disable iff (rst)
        (used_lq <= lq_free) && (used_sq <= sq_free));

    assert_stall_short_R8: assert property (@(posedge clk) disable iff (rst)
        (stall_reason != 3'd0) |->
            (disp_count < q_count) && (int'(disp_count) < int'(eff_w)));

    assert_stall_tally_R9: assert property (@(posedge clk) disable iff (rst)
        !rst |=> stall_sum == $past(stall_sum)
                              + CNT_W'($past(stall_reason) != 3'd0));

    assert_hist_tally_R10: assert property (@(posedge clk) disable iff (rst)
        !rst |=> hist_sum == $past(hist_sum) + CNT_W'(1));

    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (hist_sum == '0) && (stall_sum == '0));

endmodule

bind dispatch_stall_ctrl dispatch_stall_ctrl_chk #(
    .MAX_W  (MAX_W),
    .DEF_W  (DEF_W),
    .NSCHED (NSCHED),
    .FREE_W (FREE_W),
    .CNT_W  (CNT_W)
) chk_i (.*);

// File: tb/dispatch_stall_ctrl_tb_top.sv
module dispatch_stall_ctrl_tb_top;

    localparam int MAX_W  = 4;
    localparam int NSCHED = 2;
    localparam int FREE_W = 8;
    localparam int CNT_W  = 16;
    localparam int NVEC   = 17;

    typedef struct packed {
        logic [2:0]  qn;
        logic [2:0]  wcfg;
        logic [7:0]  rob;
        logic [7:0]  prf;
        logic [7:0]  plim;
        logic [7:0]  s0;
        logic [7:0]  s1;
        logic [7:0]  lq;
        logic [7:0]  sq;
        logic [11:0] uops;
        logic [7:0]  dst;
        logic [3:0]  ld;
        logic [3:0]  st;
        logic [3:0]  sch;
        logic [3:0]  alone;
        logic [2:0]  ecnt;
        logic [2:0]  ersn;
    } vec_t;

    // qn wcfg rob prf plim s0 s1 lq sq uops dst ld st sch alone | ecnt ersn
    localparam vec_t VECS [NVEC] = '{
        '{3'd4, 3'd4, 8'd20, 8'd20, 8'd64, 8'd8, 8'd8, 8'd4, 8'd4, 12'h249, 8'h55, 4'h0, 4'h0, 4'h0, 4'h0, 3'd4, 3'd0}, // R1 full group
        '{3'd4, 3'd0, 8'd20, 8'd20, 8'd64, 8'd8, 8'd8, 8'd4, 8'd4, 12'h249, 8'h55, 4'h0, 4'h0, 4'h0, 4'h0, 3'd2, 3'd0}, // R2 zero -> default
        '{3'd3, 3'd4, 8'd20, 8'd20, 8'd64, 8'd8, 8'd8, 8'd4, 8'd4, 12'h249, 8'h55, 4'h0, 4'h0, 4'h0, 4'h0, 3'd3, 3'd0}, // R1 queue short
        '{3'd4, 3'd4, 8'd5,  8'd20, 8'd64, 8'd8, 8'd8, 8'd4, 8'd4, 12'h492, 8'h55, 4'h0, 4'h0, 4'h0, 4'h0, 3'd2, 3'd1}, // R3 rob
        '{3'd4, 3'd4, 8'd20, 8'd3,  8'd64, 8'd8, 8'd8, 8'd4, 8'd4, 12'h249, 8'hAA, 4'h0, 4'h0, 4'h0, 4'h0, 3'd1, 3'd2}, // R4 regs
        '{3'd4, 3'd4, 8'd20, 8'd3,  8'd0,  8'd8, 8'd8, 8'd4, 8'd4, 12'h249, 8'hAA, 4'h0, 4'h0, 4'h0, 4'h0, 3'd4, 3'd0}, // R4 unbounded
        '{3'd4, 3'd4, 8'd20, 8'd20, 8'd64, 8'd2, 8'd8, 8'd4, 8'd4, 12'h249, 8'h55, 4'h0, 4'h0, 4'h0, 4'h0, 3'd2, 3'd3}, // R5 sched
        '{3'd4, 3'd4, 8'd20, 8'd20, 8'd64, 8'd8, 8'd8, 8'd1, 8'd4, 12'h249, 8'h55, 4'h5, 4'h0, 4'h0, 4'h0, 3'd2, 3'd4}, // R6 load queue
        '{3'd4, 3'd4, 8'd20, 8'd20, 8'd64, 8'd8, 8'd8, 8'd4, 8'd0, 12'h249, 8'h55, 4'h0, 4'h8, 4'h0, 4'h0, 3'd3, 3'd5}, // R6 store queue
        '{3'd4, 3'd4, 8'd20, 8'd20, 8'd64, 8'd8, 8'd8, 8'd4, 8'd4, 12'h249, 8'h55, 4'h0, 4'h0, 4'h0, 4'h2, 3'd1, 3'd6}, // R7 not first
        '{3'd4, 3'd4, 8'd20, 8'd20, 8'd64, 8'd8, 8'd8, 8'd4, 8'd4, 12'h249, 8'h55, 4'h0, 4'h0, 4'h0, 4'h1, 3'd4, 3'd0}, // R7 first ok
        '{3'd4, 3'd4, 8'd3,  8'd3,  8'd64, 8'd8, 8'd8, 8'd4, 8'd4, 12'h492, 8'hAA, 4'h0, 4'h0, 4'h0, 4'h0, 3'd1, 3'd1}, // R8 rob over regs
        '{3'd4, 3'd4, 8'd20, 8'd3,  8'd64, 8'd1, 8'd8, 8'd4, 8'd4, 12'h249, 8'hAA, 4'h0, 4'h0, 4'h0, 4'h0, 3'd1, 3'd2}, // R8 regs over sched
        '{3'd4, 3'd7, 8'd20, 8'd20, 8'd64, 8'd8, 8'd8, 8'd4, 8'd4, 12'h249, 8'h55, 4'h0, 4'h0, 4'h0, 4'h0, 3'd4, 3'd0}, // R2 clamp
        '{3'd4, 3'd4, 8'd20, 8'd20, 8'd64, 8'd2, 8'd1, 8'd4, 8'd4, 12'h249, 8'h55, 4'h0, 4'h0, 4'hA, 4'h0, 3'd3, 3'd3}, // R5 split
        '{3'd0, 3'd4, 8'd20, 8'd20, 8'd64, 8'd8, 8'd8, 8'd4, 8'd4, 12'h249, 8'h55, 4'h0, 4'h0, 4'h0, 4'h0, 3'd0, 3'd0}, // R1 empty
        '{3'd4, 3'd4, 8'd20, 8'd20, 8'd64, 8'd8, 8'd8, 8'd0, 8'd0, 12'h249, 8'h55, 4'h1, 4'h1, 4'h0, 4'h0, 3'd0, 3'd4}  // R8 lq over sq
    };

    logic                        clk = 1'b0;
    logic                        rst = 1'b1;
    logic [2:0]                  cfg_width = '0;
    logic [FREE_W-1:0]           cfg_prf_limit = '0;
    logic [2:0]                  q_count = '0;
    logic [11:0]                 q_uops = '0;
    logic [7:0]                  q_dsts = '0;
    logic [3:0]                  q_is_load = '0;
    logic [3:0]                  q_is_store = '0;
    logic [3:0]                  q_alone = '0;
    logic [3:0]                  q_sched = '0;
    logic [FREE_W-1:0]           rob_free = '0;
    logic [FREE_W-1:0]           prf_free = '0;
    logic [NSCHED*FREE_W-1:0]    sched_free = '0;
    logic [FREE_W-1:0]           lq_free = '0;
    logic [FREE_W-1:0]           sq_free = '0;
    logic [2:0]                  disp_count;
    logic [2:0]                  stall_reason;
    logic [FREE_W-1:0]           used_rob, used_prf, used_lq, used_sq;
    logic [NSCHED*FREE_W-1:0]    used_sched;
    logic [6*CNT_W-1:0]          stall_cnt;
    logic [(MAX_W+1)*CNT_W-1:0]  hist_cnt;

    int checks = 0;
    int fails  = 0;
    int exp_hist  [MAX_W+1];
    int exp_stall [6];
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dispatch_stall_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_prf_limit(cfg_prf_limit),
        .q_count(q_count), .q_uops(q_uops), .q_dsts(q_dsts), .q_is_load(q_is_load),
        .q_is_store(q_is_store), .q_alone(q_alone), .q_sched(q_sched),
        .rob_free(rob_free), .prf_free(prf_free), .sched_free(sched_free),
        .lq_free(lq_free), .sq_free(sq_free), .disp_count(disp_count),
        .stall_reason(stall_reason), .used_rob(used_rob), .used_prf(used_prf),
        .used_sched(used_sched), .used_lq(used_lq), .used_sq(used_sq),
        .stall_cnt(stall_cnt), .hist_cnt(hist_cnt)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic check_counters(input string tag);
        for (int b = 0; b <= MAX_W; b++)
            chk($sformatf("%s R10 hist bin %0d", tag, b),
                int'(hist_cnt[b*CNT_W +: CNT_W]), exp_hist[b]);
        for (int r = 0; r < 6; r++)
            chk($sformatf("%s R9 stall cnt reason %0d", tag, r + 1),
                int'(stall_cnt[r*CNT_W +: CNT_W]), exp_stall[r]);
    endtask

    task automatic clear_model();
        for (int b = 0; b <= MAX_W; b++) exp_hist[b] = 0;
        for (int r = 0; r < 6; r++) exp_stall[r] = 0;
    endtask

    task automatic idle_inputs();
        q_count   = '0;
        cfg_width = 3'd4;
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        clear_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: counters cleared by reset
        check_counters("reset");
        rst = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            int sum_u, sum_d, sum_l;
            cfg_width     = VECS[v].wcfg;
            cfg_prf_limit = VECS[v].plim;
            q_count       = VECS[v].qn;
            q_uops        = VECS[v].uops;
            q_dsts        = VECS[v].dst;
            q_is_load     = VECS[v].ld;
            q_is_store    = VECS[v].st;
            q_alone       = VECS[v].alone;
            q_sched       = VECS[v].sch;
            rob_free      = VECS[v].rob;
            prf_free      = VECS[v].prf;
            sched_free    = {VECS[v].s1, VECS[v].s0};
            lq_free       = VECS[v].lq;
            sq_free       = VECS[v].sq;
            #1;
            sum_u = 0; sum_d = 0; sum_l = 0;
            for (int i = 0; i < int'(VECS[v].ecnt); i++) begin
                sum_u += int'(VECS[v].uops[i*3 +: 3]);
                sum_d += int'(VECS[v].dst[i*2 +: 2]);
                sum_l += int'(VECS[v].ld[i]);
            end
            chk($sformatf("vec %0d disp_count (R1 group size)", v),
                int'(disp_count), int'(VECS[v].ecnt));
            chk($sformatf("vec %0d R8 stall_reason", v),
                int'(stall_reason), int'(VECS[v].ersn));
            chk($sformatf("vec %0d R12 used_rob", v), int'(used_rob), sum_u);
            chk($sformatf("vec %0d R12 used_prf", v), int'(used_prf), sum_d);
            chk($sformatf("vec %0d R12 used_lq", v), int'(used_lq), sum_l);
            @(posedge clk);
            exp_hist[VECS[v].ecnt]++;
            if (VECS[v].ersn != 3'd0)
                exp_stall[VECS[v].ersn - 3'd1]++;
            @(negedge clk);
        end

        idle_inputs();
        // R9 and R10: tallies after the vector table
        check_counters("table");

        // R5: per-scheduler usage with a split group
        cfg_width  = 3'd4;
        q_count    = 3'd4;
        q_sched    = 4'hA;
        sched_free = {8'd8, 8'd8};
        q_uops     = 12'h249;
        q_dsts     = 8'h55;
        q_is_load  = '0;
        q_is_store = '0;
        q_alone    = '0;
        rob_free   = 8'd20;
        prf_free   = 8'd20;
        lq_free    = 8'd4;
        sq_free    = 8'd4;
        cfg_prf_limit = 8'd64;
        #1;
        chk("R5 used_sched scheduler 0", int'(used_sched[7:0]), 2);
        chk("R5 used_sched scheduler 1", int'(used_sched[15:8]), 2);
        // R6: a store-only group consumes store entries only
        q_is_store = 4'hF;
        #1;
        chk("R6 used_sq", int'(used_sq), 4);
        chk("R6 used_lq", int'(used_lq), 0);
        idle_inputs();

        // R11: reset mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clear_model();
        check_counters("mid reset");
        rst = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        exp_hist[0] = 3;
        // R10: idle cycles land in bin 0 without stalls
        check_counters("idle");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule